// File: doc/BRIEF.md
# Three-Stream Banked Vector Memory

This block is the memory side of an element-wise vector adder that computes C[i] = A[i] + B[i]. Four single-port memory banks are interleaved on the low address bits. Three streams run against them at once: one read stream for operand A, one read stream for operand B, and one write stream for the result C. A bank serves one stream per cycle and then stays occupied for a second cycle. Streams that target different banks go ahead in parallel. When two streams want the same bank, or a stream wants a bank that is still occupied, the loser waits and keeps its request.

Operand pairs feed a four-stage add pipeline that never stalls. Its results go into a small queue, and the C write stream drains that queue. A credit count limits how many elements can be in flight, so the queue cannot overflow. A run is launched with a start pulse that carries three base addresses and a vector length. While no run is active, a host port fills and reads back the banks.

Top module: `vbm_vadd_mem`

## Requirements
- R1: After reset, `busy`, `done` and `cw_valid` are low.
- R2: A run of length N writes, for every i in 0..N-1, the value (A[base_a+i] + B[base_b+i]) mod 2^16 to address base_c+i. All address arithmetic wraps modulo 2^8.
- R3: The bank of an address is its two least significant bits. In any cycle no two streams are granted the same bank.
- R4: A bank granted to a stream in one cycle is granted to no stream in the next cycle.
- R5: When streams compete for one free bank, A wins over B and B wins over C.
- R6: A stream that requests without a grant requests again in the next cycle with the same address.
- R7: A result enters the write queue exactly four cycles after its operand pair enters the add pipeline.
- R8: `done` is a one-cycle pulse. It is high in the same cycle that the last C write appears on `cw_*`, and `busy` is low in that cycle. Each run pulses `done` exactly once.
- R9: C writes appear on `cw_*` in element order, one per element, at base_c, base_c+1, and so on.
- R10: A start pulse while `busy` is high is ignored. A start with `vlen` = 0 is ignored: no run starts, no write occurs and `done` does not pulse.
- R11: A host write (`host_en`=1, `host_we`=1) updates memory only while idle, and `host_rdata` returns a word two cycles after a host read. Host accesses during a run are ignored.
- R12: Bank conflicts cost throughput. With base_a, base_b and base_c all in the same bank, a run takes more cycles than the same length with the three bases in different banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run when idle |
| base_a | input | 8 | First address of operand A |
| base_b | input | 8 | First address of operand B |
| base_c | input | 8 | First address of result C |
| vlen | input | 9 | Element count, 0 to 256 |
| busy | output | 1 | High while a run is active |
| done | output | 1 | One-cycle pulse with the last write |
| host_en | input | 1 | Host access strobe, honoured when idle |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, two cycles after the read |
| cw_valid | output | 1 | A C word was written in the previous cycle |
| cw_addr | output | 8 | Address of that C word |
| cw_data | output | 16 | Value of that C word |

## Verification
The assertions assume that `start` and the host port are driven only between clock edges. They also assume that the C region of a run does not overlap that run's A or B region, because overlapping regions would make the sums depend on bank timing. The stimulus places every C region in addresses that the same run does not read. It issues host accesses and extra start pulses during runs only to show that they are ignored. A sweep over all 64 combinations of bank offsets for the three bases drives every pattern of contention through the grant logic.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  // which stream owns a bank access in a cycle
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RDA  = 2'd1,
    OWN_RDB  = 2'd2,
    OWN_WRC  = 2'd3
  } bank_owner_e;

  localparam int unsigned ADD_STAGES = 4;
endpackage

// File: rtl/vbm_bank.sv
module vbm_bank #(
  parameter int DW  = 16,
  parameter int BAW = 6
) (
  input  logic           clk,
  input  logic           en,
  input  logic           we,
  input  logic [BAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  localparam int WORDS = 1 << BAW;
  logic [DW-1:0] ram [WORDS];

  // single port, read-first, registered read
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) ram[addr] <= wdata;
      rdata <= ram[addr];
    end
  end
endmodule

// File: rtl/vbm_addpipe.sv
module vbm_addpipe #(
  parameter int DW     = 16,
  parameter int STAGES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_v,
  output logic [DW-1:0] out_sum
);
  logic [DW-1:0]     dat [STAGES];
  logic [STAGES-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[STAGES-2:0], in_v};
  end

  always_ff @(posedge clk) begin
    dat[0] <= in_a + in_b;
    for (int k = 1; k < STAGES; k++) dat[k] <= dat[k-1];
  end

  assign out_v   = vld[STAGES-1];
  assign out_sum = dat[STAGES-1];
endmodule

// File: rtl/vbm_fifo.sv
module vbm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  buf_q [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) buf_q[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout  = buf_q[rp];
  assign empty = (cnt == '0);
endmodule

// File: rtl/vbm_vadd_mem.sv
module vbm_vadd_mem #(
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int NMOD     = 4,
  parameter int CQ_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  input  logic [AW:0]   vlen,
  output logic          busy,
  output logic          done,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          cw_valid,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data
);
  import vbm_pkg::*;

  localparam int MB  = $clog2(NMOD);
  localparam int BAW = AW - MB;
  localparam int LW  = AW + 1;
  localparam int CW  = $clog2(CQ_DEPTH + 1);

  // run state
  logic          run;
  logic [AW-1:0] ba_q, bb_q, bc_q;
  logic [LW-1:0] vl_q, ia, jc;
  logic          a_got, b_got;
  logic [CW-1:0] inflight;

  // stream requests and grants
  logic          issuing, a_req, b_req, c_req, a_gnt, b_gnt, c_gnt, adv;
  logic [AW-1:0] a_addr, b_addr, c_addr;
  logic [MB-1:0] ma, mb, mc;
  logic          host_ok;

  // bank side
  logic [NMOD-1:0] mod_act, mod_en, mod_we, mod_busy;
  logic [BAW-1:0]  mod_addr [NMOD];
  logic [DW-1:0]   mod_wd   [NMOD];
  logic [DW-1:0]   mod_rd   [NMOD];

  // operand return and pairing
  logic          a_rv, b_rv, a_hv, b_hv, fire, host_rv;
  logic [MB-1:0] a_rm, b_rm, host_rm;
  logic [DW-1:0] a_hold, b_hold;

  // result path
  logic          sum_v, cq_empty;
  logic [DW-1:0] sum_d, cq_dout;

  assign busy    = run;
  assign host_ok = host_en & ~run;
  assign issuing = run && (ia < vl_q) && (inflight < CW'(CQ_DEPTH));
  assign a_addr  = ba_q + ia[AW-1:0];
  assign b_addr  = bb_q + ia[AW-1:0];
  assign c_addr  = bc_q + jc[AW-1:0];
  assign ma      = a_addr[MB-1:0];
  assign mb      = b_addr[MB-1:0];
  assign mc      = c_addr[MB-1:0];
  assign a_req   = issuing & ~a_got;
  assign b_req   = issuing & ~b_got;
  assign c_req   = run & ~cq_empty;

  // fixed priority per bank: A, then B, then C
  assign a_gnt = a_req & ~mod_busy[ma];
  assign b_gnt = b_req & ~mod_busy[mb] & ~(a_gnt && (ma == mb));
  assign c_gnt = c_req & ~mod_busy[mc] & ~(a_gnt && (ma == mc))
                       & ~(b_gnt && (mb == mc));
  assign adv   = issuing & (a_got | a_gnt) & (b_got | b_gnt);
  assign fire  = a_hv & b_hv;

  for (genvar m = 0; m < NMOD; m++) begin : g_bank
    localparam logic [MB-1:0] MI = MB'(m);
    bank_owner_e   own;
    logic          hit_h;
    logic [BAW-1:0] addr_m;

    always_comb begin
      if      (a_gnt && ma == MI) own = OWN_RDA;
      else if (b_gnt && mb == MI) own = OWN_RDB;
      else if (c_gnt && mc == MI) own = OWN_WRC;
      else                        own = OWN_NONE;
      hit_h = host_ok && (host_addr[MB-1:0] == MI);
      unique case (own)
        OWN_RDA: addr_m = a_addr[AW-1:MB];
        OWN_RDB: addr_m = b_addr[AW-1:MB];
        OWN_WRC: addr_m = c_addr[AW-1:MB];
        default: addr_m = host_addr[AW-1:MB];
      endcase
    end

    assign mod_act[m]  = (own != OWN_NONE);
    assign mod_en[m]   = (own != OWN_NONE) | hit_h;
    assign mod_we[m]   = (own == OWN_WRC) | (own == OWN_NONE && hit_h && host_we);
    assign mod_addr[m] = addr_m;
    assign mod_wd[m]   = (own == OWN_WRC) ? cq_dout : host_wdata;

    vbm_bank #(.DW(DW), .BAW(BAW)) u_bank (
      .clk(clk), .en(mod_en[m]), .we(mod_we[m]), .addr(mod_addr[m]),
      .wdata(mod_wd[m]), .rdata(mod_rd[m])
    );
  end

  vbm_addpipe #(.DW(DW), .STAGES(ADD_STAGES)) u_add (
    .clk(clk), .rst(rst), .in_v(fire), .in_a(a_hold), .in_b(b_hold),
    .out_v(sum_v), .out_sum(sum_d)
  );

  vbm_fifo #(.W(DW), .DEPTH(CQ_DEPTH)) u_cq (
    .clk(clk), .rst(rst), .push(sum_v), .din(sum_d), .pop(c_gnt),
    .dout(cq_dout), .empty(cq_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;  done <= 1'b0;  vl_q <= '0;
      ba_q <= '0;   bb_q <= '0;    bc_q <= '0;
      ia <= '0;     jc <= '0;      a_got <= 1'b0;  b_got <= 1'b0;
      inflight <= '0;  mod_busy <= '0;
      a_rv <= 1'b0; b_rv <= 1'b0;  a_rm <= '0;  b_rm <= '0;
      a_hv <= 1'b0; b_hv <= 1'b0;  a_hold <= '0; b_hold <= '0;
      host_rv <= 1'b0; host_rm <= '0; host_rdata <= '0;
      cw_valid <= 1'b0; cw_addr <= '0; cw_data <= '0;
    end else begin
      done     <= 1'b0;
      mod_busy <= mod_act;
      a_rv <= a_gnt;  a_rm <= ma;
      b_rv <= b_gnt;  b_rm <= mb;
      if (a_rv) a_hold <= mod_rd[a_rm];
      if (b_rv) b_hold <= mod_rd[b_rm];
      a_hv <= (a_hv & ~fire) | a_rv;
      b_hv <= (b_hv & ~fire) | b_rv;
      host_rv <= host_ok & ~host_we;
      host_rm <= host_addr[MB-1:0];
      if (host_rv) host_rdata <= mod_rd[host_rm];
      cw_valid <= c_gnt;
      if (c_gnt) begin
        cw_addr <= c_addr;
        cw_data <= cq_dout;
      end
      if (!run) begin
        if (start && vlen != '0) begin
          run <= 1'b1;  vl_q <= vlen;
          ba_q <= base_a;  bb_q <= base_b;  bc_q <= base_c;
          ia <= '0;  jc <= '0;  a_got <= 1'b0;  b_got <= 1'b0;
          inflight <= '0;
        end
      end else begin
        if (adv) ia <= ia + 1'b1;
        a_got    <= adv ? 1'b0 : (a_got | a_gnt);
        b_got    <= adv ? 1'b0 : (b_got | b_gnt);
        inflight <= inflight + CW'(adv) - CW'(c_gnt);
        if (c_gnt) begin
          jc <= jc + 1'b1;
          if (jc == vl_q - LW'(1)) begin
            run  <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vbm_vadd_mem_chk.sv
module vbm_vadd_mem_chk #(
  parameter int AW   = 8,
  parameter int NMOD = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            a_req,
  input logic            b_req,
  input logic            c_req,
  input logic            a_gnt,
  input logic            b_gnt,
  input logic            c_gnt,
  input logic [AW-1:0]   a_addr,
  input logic [AW-1:0]   b_addr,
  input logic [AW-1:0]   c_addr,
  input logic [NMOD-1:0] mod_act,
  input logic            fire,
  input logic            push,
  input logic            done,
  input logic            cw_valid,
  input logic            busy
);
  localparam int MB = $clog2(NMOD);

  // R3: no two streams granted the same bank in one cycle
  p_excl_ab_r3: assert property (@(posedge clk) disable iff (rst)
    (a_gnt && b_gnt) |-> (a_addr[MB-1:0] != b_addr[MB-1:0]));
  p_excl_ac_r3: assert property (@(posedge clk) disable iff (rst)
    (a_gnt && c_gnt) |-> (a_addr[MB-1:0] != c_addr[MB-1:0]));
  p_excl_bc_r3: assert property (@(posedge clk) disable iff (rst)
    (b_gnt && c_gnt) |-> (b_addr[MB-1:0] != c_addr[MB-1:0]));

  // R4: a bank stays occupied for the cycle after its grant
  p_occupy_r4: assert property (@(posedge clk) disable iff (rst)
    (|mod_act) |-> ((mod_act & $past(mod_act)) == '0));

  // R5: priority A over B over C
  p_prio_ab_r5: assert property (@(posedge clk) disable iff (rst)
    (a_req && b_req && a_addr[MB-1:0] == b_addr[MB-1:0]) |-> !b_gnt);
  p_prio_bc_r5: assert property (@(posedge clk) disable iff (rst)
    (b_req && c_req && b_addr[MB-1:0] == c_addr[MB-1:0]) |-> !c_gnt);

  // R6: a losing stream holds its request and address
  p_hold_a_r6: assert property (@(posedge clk) disable iff (rst)
    (a_req && !a_gnt) |=> (a_req && $stable(a_addr)));
  p_hold_b_r6: assert property (@(posedge clk) disable iff (rst)
    (b_req && !b_gnt) |=> (b_req && $stable(b_addr)));
  p_hold_c_r6: assert property (@(posedge clk) disable iff (rst)
    (c_req && !c_gnt) |=> (c_req && $stable(c_addr)));

  // R7: four-stage add latency
  p_lat_in_r7: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(fire, 4));
  p_lat_out_r7: assert property (@(posedge clk) disable iff (rst)
    fire |-> ##4 push);

  // R8: done is a single pulse alongside the last write
  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cw_valid && !busy));
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind vbm_vadd_mem vbm_vadd_mem_chk #(.AW(AW), .NMOD(NMOD)) u_chk (
  .clk(clk), .rst(rst),
  .a_req(a_req), .b_req(b_req), .c_req(c_req),
  .a_gnt(a_gnt), .b_gnt(b_gnt), .c_gnt(c_gnt),
  .a_addr(a_addr), .b_addr(b_addr), .c_addr(c_addr),
  .mod_act(mod_act), .fire(fire), .push(sum_v),
  .done(done), .cw_valid(cw_valid), .busy(busy)
);

// File: tb/vbm_vadd_mem_test.sv
module vbm_vadd_mem_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  base_a = '0, base_b = '0, base_c = '0;
  logic [8:0]  vlen = '0;
  logic        busy, done;
  logic        host_en = 1'b0, host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        cw_valid;
  logic [7:0]  cw_addr;
  logic [15:0] cw_data;

  vbm_vadd_mem uut (
    .clk(clk), .rst(rst), .start(start), .base_a(base_a), .base_b(base_b),
    .base_c(base_c), .vlen(vlen), .busy(busy), .done(done),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mdl [256];
  logic [15:0] exp_c [256];
  logic [7:0]  mon_bc;
  int          wcount, done_cnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write monitor: R2 values, R9 order
  always @(negedge clk) begin
    if (!rst) begin
      if (cw_valid) begin
        chk(cw_addr == 8'(mon_bc + wcount), "R9 write order", cw_addr, 8'(mon_bc + wcount));
        chk(cw_data == exp_c[wcount[7:0]], "R2 sum value", cw_data, exp_c[wcount[7:0]]);
        wcount++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic host_wr(input logic [7:0] a, input logic [15:0] d);
    host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [15:0] d);
    host_en = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_en = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic run_vec(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                         input int n, input bit poke, output int cycles);
    int k;
    for (int i = 0; i < n; i++) exp_c[i] = mdl[8'(a + i)] + mdl[8'(b + i)];
    mon_bc = c; wcount = 0; done_cnt = 0;
    base_a = a; base_b = b; base_c = c; vlen = 9'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    if (poke) begin
      @(negedge clk); k++;
      // R10: restart attempt while busy; R11: host write while busy
      base_a = 8'd200; base_b = 8'd201; base_c = 8'd202; vlen = 9'd3; start = 1'b1;
      host_en = 1'b1; host_we = 1'b1; host_addr = 8'd40; host_wdata = 16'hDEAD;
      @(negedge clk); k++;
      start = 1'b0; host_en = 1'b0; host_we = 1'b0;
    end
    while (!done && k < 4000) begin
      @(negedge clk); k++;
    end
    chk(k < 4000, "R8 run completes", k, 4000);
    @(negedge clk);
    chk(wcount == n, "R9 write count", wcount, n);
    chk(done_cnt == 1, "R8 single done", done_cnt, 1);
    chk(busy == 1'b0, "R8 idle after done", busy, 0);
    for (int i = 0; i < n; i++) mdl[8'(c + i)] = exp_c[i];
    cycles = k;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int t_spread, t_cong, t_dummy;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(cw_valid == 1'b0, "R1 cw_valid reset", cw_valid, 0);

    // R11: fill memory while idle
    for (int i = 0; i < 256; i++) begin
      mdl[i] = 16'(i * 40503 + 12345);
      host_wr(8'(i), mdl[i]);
    end
    host_rd(8'd77, rd);
    chk(rd == mdl[77], "R11 host readback", rd, mdl[77]);

    // R10: zero length start ignored
    wcount = 0; done_cnt = 0;
    base_a = 8'd0; base_b = 8'd1; base_c = 8'd2; vlen = 9'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R10 zero length no run", busy, 0);
    chk(done_cnt == 0, "R10 zero length no done", done_cnt, 0);
    chk(wcount == 0, "R10 zero length no write", wcount, 0);

    // R2/R12: spread banks, with busy-time pokes for R10/R11
    run_vec(8'd0, 8'd65, 8'd130, 32, 1'b1, t_spread);
    host_rd(8'd40, rd);
    chk(rd == mdl[40], "R11 host write during run ignored", rd, mdl[40]);
    for (int i = 0; i < 32; i++) begin
      host_rd(8'(130 + i), rd);
      chk(rd == mdl[8'(130 + i)], "R2 memory content", rd, mdl[8'(130 + i)]);
    end

    // R12: all three bases in bank 0
    run_vec(8'd4, 8'd68, 8'd200, 32, 1'b0, t_cong);
    chk(t_cong > t_spread, "R12 conflicts slow the run", t_cong, t_spread);

    // R2: address wrap and single element
    run_vec(8'd20, 8'd100, 8'd250, 16, 1'b0, t_dummy);
    host_rd(8'd3, rd);
    chk(rd == mdl[3], "R2 wrapped write", rd, mdl[3]);
    run_vec(8'd5, 8'd6, 8'd7, 1, 1'b0, t_dummy);

    // R3/R4/R5/R6: sweep every bank offset combination
    for (int da = 0; da < 4; da++)
      for (int db = 0; db < 4; db++)
        for (int dc = 0; dc < 4; dc++)
          run_vec(8'(16 + da), 8'(48 + db), 8'(96 + dc), 6, 1'b0, t_dummy);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule